// File: doc/BRIEF.md
# Latency-Bandwidth Pipe Memory Timing Model

This block is a memory timing model that sits behind an AXI4 slave port and imitates a memory system by two parameters only: how long a response takes and how many transactions may be in flight. It has no notion of banks, rows or refresh. A read response leaves a fixed, programmable number of cycles after its address is accepted. A write response leaves a separately programmed number of cycles after the final data beat. Data is held in a small word-addressed functional store inside the block, so software running against the model sees coherent contents.

Read and write each have their own cap on outstanding transactions. Once the cap is reached the matching address channel stops accepting. Sustained throughput is therefore set by Little's Law, outstanding cap over round-trip time, and no other throttle exists. Latencies and caps sit in four runtime registers written through a small configuration port. A new setting applies to transactions accepted after the register write. Transactions already in flight keep the latency they were accepted with.

Bursts are incrementing and full-width, one data word per beat. The burst length field is honoured up to its full range. Responses in each direction come back in acceptance order and always carry the OKAY code.

Top module: `lbp_mem_model`

## Requirements
- R1: With no older read outstanding, the first read data beat (`rvalid` high) appears in the cycle right after clock edge k+RL, where k is the edge at which the read address handshake happened and RL is the read latency register (select code 0). RL = 0 puts it in the cycle right after edge k.
- R2: With no older write outstanding, `bvalid` appears in the cycle right after clock edge k+WL, where k is the edge that accepted the beat carrying `wlast` and WL is the write latency register (select code 1).
- R3: A read is outstanding from its address handshake until its final data beat handshakes. `arready` is low whenever the outstanding reads equal min(read cap, MAX_OUT), where the read cap has select code 2. A cap of 0 blocks all reads.
- R4: A write is outstanding from its address handshake until its response handshakes. `awready` is low whenever the outstanding writes equal min(write cap, MAX_OUT), where the write cap has select code 3. `awready` is also low while a burst's data beats are still being collected. `wready` is high only in that collection window.
- R5: With `arvalid` and `rready` held high, single-beat reads, read latency L and effective read cap N, exactly K·min(N, L+2) read beats complete in any steady-state window of K·(L+2) cycles.
- R6: Within each direction, responses return in acceptance order. `rid` and `bid` echo the ID of the request they answer.
- R7: A configuration write (`cfg_we` with `cfg_sel` and `cfg_wdata`) changes only transactions accepted after the edge that stores it. A read already in flight keeps its original latency.
- R8: Write beat b of a burst stores `wdata` into word ((addr >> 2) + b) mod MEM_WORDS, only in the byte lanes whose `wstrb` bit is set. A read burst of `arlen`+1 beats returns those words in increasing order, with `rlast` set only on beat `arlen`.
- R9: While `rvalid` or `bvalid` is high and the matching ready is low, the valid stays high and the ID and last flag stay unchanged.
- R10: After reset, `rvalid`, `bvalid` and `wready` are low, and `arready` and `awready` are high. The reset latencies are 4 (read) and 2 (write). Both reset caps are 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 read latency, 1 write latency, 2 read cap, 3 write cap |
| cfg_wdata | input | VAL_W | Value to store |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awid | input | ID_W | Write ID |
| awaddr | input | ADDR_W | Write byte address |
| awlen | input | 8 | Write burst length minus one |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte enables |
| wlast | input | 1 | Final write beat |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bid | output | ID_W | Write response ID |
| bresp | output | 2 | Write response code (always OKAY) |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| arid | input | ID_W | Read ID |
| araddr | input | ADDR_W | Read byte address |
| arlen | input | 8 | Read burst length minus one |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rid | output | ID_W | Read data ID |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code (always OKAY) |
| rlast | output | 1 | Final read beat |

## Verification
The hardest state to reach is the steady-state pipeline, where the outstanding cap and the latency together set the rate. Reaching it needs a continuous stream of address requests that the block throttles by itself, so the bench holds `arvalid` and `rready` high and, after a warm-up, counts beats over windows sized to whole round-trip periods. That count is compared with the Little's Law figure for several latency and cap pairs. A second hard case is a latency change while a read is in flight. The bench issues a slow read, lowers the latency, then issues a fast read. It checks that the slow read keeps its original latency and still leaves first.

// File: rtl/lbp_pkg.sv
package lbp_pkg;
  typedef enum logic [1:0] {
    SEL_RD_LAT = 2'd0,
    SEL_WR_LAT = 2'd1,
    SEL_RD_CAP = 2'd2,
    SEL_WR_CAP = 2'd3
  } cfg_sel_e;

  localparam int          AXI_LEN_W = 8;
  localparam logic [1:0]  RESP_OKAY = 2'b00;
endpackage

// File: rtl/lbp_delay_queue.sv
// In-order queue whose head is released once its own countdown expires.
module lbp_delay_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int LAT_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [W-1:0]                  push_data,
  input  logic [LAT_W-1:0]              push_lat,
  input  logic                          pop,
  output logic                          head_due,
  output logic [W-1:0]                  head_data,
  output logic [$clog2(DEPTH+1)-1:0]    occupancy
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     data_q [DEPTH];
  logic [LAT_W-1:0] wait_q [DEPTH];
  logic [LAT_W-1:0] wait_d [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] occ_q, occ_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic load;
    assign load = push && (wr_ptr_q == PTR_W'(i));

    always_comb begin
      if (load)                 wait_d[i] = push_lat;
      else if (wait_q[i] != '0) wait_d[i] = wait_q[i] - 1'b1;
      else                      wait_d[i] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q[i] <= '0;
      else        wait_q[i] <= wait_d[i];
    end

    always_ff @(posedge clk) begin
      if (load) data_q[i] <= push_data;
    end
  end

  always_comb begin
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    occ_d    = occ_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  assign head_due  = (occ_q != '0) && (wait_q[rd_ptr_q] == '0);
  assign head_data = data_q[rd_ptr_q];
  assign occupancy = occ_q;
endmodule

// File: rtl/lbp_cfg_regs.sv
// Four runtime settings, loaded through a select/strobe port.
module lbp_cfg_regs #(
  parameter int               VAL_W       = 8,
  parameter logic [VAL_W-1:0] RD_LAT_INIT = 4,
  parameter logic [VAL_W-1:0] WR_LAT_INIT = 2,
  parameter logic [VAL_W-1:0] RD_CAP_INIT = 4,
  parameter logic [VAL_W-1:0] WR_CAP_INIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [VAL_W-1:0] cfg_wdata,
  output logic [VAL_W-1:0] rd_lat,
  output logic [VAL_W-1:0] wr_lat,
  output logic [VAL_W-1:0] rd_cap,
  output logic [VAL_W-1:0] wr_cap
);
  localparam int NREG = 4;
  logic [VAL_W-1:0] init_v [NREG];
  logic [VAL_W-1:0] val_q  [NREG];

  assign init_v[0] = RD_LAT_INIT;
  assign init_v[1] = WR_LAT_INIT;
  assign init_v[2] = RD_CAP_INIT;
  assign init_v[3] = WR_CAP_INIT;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic ld;
    assign ld = cfg_we && (cfg_sel == 2'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q[i] <= init_v[i];
      else if (ld) val_q[i] <= cfg_wdata;
    end
  end

  assign rd_lat = val_q[lbp_pkg::SEL_RD_LAT];
  assign wr_lat = val_q[lbp_pkg::SEL_WR_LAT];
  assign rd_cap = val_q[lbp_pkg::SEL_RD_CAP];
  assign wr_cap = val_q[lbp_pkg::SEL_WR_CAP];
endmodule

// File: rtl/lbp_func_mem.sv
// Word-organised functional store with per-byte write enables.
module lbp_func_mem #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [DATA_W/8-1:0]      wr_strb,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int LANES = DATA_W / 8;
  logic [DATA_W-1:0] store [WORDS];

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_strb[b]) store[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  assign rd_data = store[rd_idx];
endmodule

// File: rtl/lbp_mem_model.sv
module lbp_mem_model
  import lbp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 4,
  parameter int VAL_W     = 8,
  parameter int MAX_OUT   = 4,
  parameter int MEM_WORDS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [VAL_W-1:0]     cfg_wdata,
  input  logic                 awvalid,
  output logic                 awready,
  input  logic [ID_W-1:0]      awid,
  input  logic [ADDR_W-1:0]    awaddr,
  input  logic [7:0]           awlen,
  input  logic                 wvalid,
  output logic                 wready,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W/8-1:0]  wstrb,
  input  logic                 wlast,
  output logic                 bvalid,
  input  logic                 bready,
  output logic [ID_W-1:0]      bid,
  output logic [1:0]           bresp,
  input  logic                 arvalid,
  output logic                 arready,
  input  logic [ID_W-1:0]      arid,
  input  logic [ADDR_W-1:0]    araddr,
  input  logic [7:0]           arlen,
  output logic                 rvalid,
  input  logic                 rready,
  output logic [ID_W-1:0]      rid,
  output logic [DATA_W-1:0]    rdata,
  output logic [1:0]           rresp,
  output logic                 rlast
);
  localparam int IDX_W   = $clog2(MEM_WORDS);
  localparam int BYTE_SH = $clog2(DATA_W/8);
  localparam int CNT_W   = $clog2(MAX_OUT+1);
  localparam int RE_W    = ID_W + IDX_W + AXI_LEN_W;
  localparam logic [VAL_W-1:0] OUT_V = VAL_W'(MAX_OUT);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  // runtime settings
  logic [VAL_W-1:0] rd_lat, wr_lat, rd_cap, wr_cap;
  lbp_cfg_regs #(.VAL_W(VAL_W)) u_cfg (
    .clk(clk), .rst_n(arst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_lat(rd_lat), .wr_lat(wr_lat),
    .rd_cap(rd_cap), .wr_cap(wr_cap)
  );

  logic [CNT_W-1:0] rd_lim, wr_lim;
  always_comb begin
    rd_lim = (rd_cap > OUT_V) ? CNT_W'(MAX_OUT) : CNT_W'(rd_cap);
    wr_lim = (wr_cap > OUT_V) ? CNT_W'(MAX_OUT) : CNT_W'(wr_cap);
  end

  // ---------------- read side ----------------
  logic                 ar_fire, r_fire, rq_pop, rq_due;
  logic [RE_W-1:0]      rq_head;
  logic [CNT_W-1:0]     rd_occ;
  logic [ID_W-1:0]      head_id;
  logic [IDX_W-1:0]     head_idx;
  logic [AXI_LEN_W-1:0] head_len;
  logic [AXI_LEN_W-1:0] rbeat_q, rbeat_d;
  logic [IDX_W-1:0]     rd_idx;

  assign arready = (rd_occ < rd_lim);
  assign ar_fire = arvalid && arready;

  lbp_delay_queue #(.W(RE_W), .DEPTH(MAX_OUT), .LAT_W(VAL_W)) u_rq (
    .clk(clk), .rst_n(arst_n), .push(ar_fire),
    .push_data({arid, araddr[BYTE_SH +: IDX_W], arlen}),
    .push_lat(rd_lat), .pop(rq_pop), .head_due(rq_due),
    .head_data(rq_head), .occupancy(rd_occ)
  );

  assign {head_id, head_idx, head_len} = rq_head;
  assign rvalid = rq_due;
  assign rid    = head_id;
  assign rlast  = (rbeat_q == head_len);
  assign rresp  = RESP_OKAY;
  assign r_fire = rvalid && rready;
  assign rq_pop = r_fire && rlast;
  assign rd_idx = head_idx + rbeat_q[IDX_W-1:0];

  always_comb begin
    rbeat_d = rbeat_q;
    if (r_fire) rbeat_d = rlast ? '0 : rbeat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     rbeat_q <= '0;
    else if (r_fire) rbeat_q <= rbeat_d;
  end

  // ---------------- write side ----------------
  logic             aw_fire, w_fire, w_end, b_fire, wq_due;
  logic             aw_open_q, aw_open_d;
  logic [IDX_W-1:0] w_idx_q, w_idx_d;
  logic [ID_W-1:0]  w_id_q;
  logic [ID_W-1:0]  wq_head;
  logic [CNT_W-1:0] wr_occ;
  logic             w_en;

  assign awready = !aw_open_q && (wr_occ < wr_lim);
  assign aw_fire = awvalid && awready;
  assign wready  = aw_open_q;
  assign w_fire  = wvalid && wready;
  assign w_end   = w_fire && wlast;
  assign w_en    = aw_fire || w_fire;

  always_comb begin
    aw_open_d = aw_open_q;
    if (aw_fire)    aw_open_d = 1'b1;
    else if (w_end) aw_open_d = 1'b0;
    w_idx_d = aw_fire ? awaddr[BYTE_SH +: IDX_W] : w_idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) aw_open_q <= 1'b0;
    else         aw_open_q <= aw_open_d;
  end

  always_ff @(posedge clk) begin
    if (w_en)    w_idx_q <= w_idx_d;
    if (aw_fire) w_id_q  <= awid;
  end

  lbp_delay_queue #(.W(ID_W), .DEPTH(MAX_OUT), .LAT_W(VAL_W)) u_wq (
    .clk(clk), .rst_n(arst_n), .push(w_end), .push_data(w_id_q),
    .push_lat(wr_lat), .pop(b_fire), .head_due(wq_due),
    .head_data(wq_head), .occupancy(wr_occ)
  );

  assign bvalid = wq_due;
  assign bid    = wq_head;
  assign bresp  = RESP_OKAY;
  assign b_fire = bvalid && bready;

  // ---------------- functional store ----------------
  lbp_func_mem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .wr_en(w_fire), .wr_idx(w_idx_q), .wr_data(wdata),
    .wr_strb(wstrb), .rd_idx(rd_idx), .rd_data(rdata)
  );
endmodule

// File: rtl/lbp_mem_model_chk.sv
module lbp_mem_model_chk #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arvalid,
  input logic             arready,
  input logic             awvalid,
  input logic             awready,
  input logic             wvalid,
  input logic             wready,
  input logic             wlast,
  input logic             rvalid,
  input logic             rready,
  input logic             rlast,
  input logic [ID_W-1:0]  rid,
  input logic             bvalid,
  input logic             bready,
  input logic [ID_W-1:0]  bid,
  input logic [CNT_W-1:0] rd_occ,
  input logic [CNT_W-1:0] wr_occ,
  input logic [CNT_W-1:0] rd_lim,
  input logic [CNT_W-1:0] wr_lim
);
  AST_RD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && arready) |=> (rd_occ <= $past(rd_lim))); // R3

  AST_WR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && awready) |=> (wr_occ < $past(wr_lim))); // R4

  AST_RD_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rready && rlast) |=>
      (rd_occ == $past(rd_occ) + CNT_W'($past(arvalid && arready)) - 1'b1)); // R3

  AST_WR_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && bready) |=>
      (wr_occ == $past(wr_occ) + CNT_W'($past(wvalid && wready && wlast)) - 1'b1)); // R4

  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rid) && $stable(rlast))); // R9

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bid))); // R9
endmodule

bind lbp_mem_model lbp_mem_model_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(arst_n),
  .arvalid(arvalid), .arready(arready), .awvalid(awvalid), .awready(awready),
  .wvalid(wvalid), .wready(wready), .wlast(wlast),
  .rvalid(rvalid), .rready(rready), .rlast(rlast), .rid(rid),
  .bvalid(bvalid), .bready(bready), .bid(bid),
  .rd_occ(rd_occ), .wr_occ(wr_occ), .rd_lim(rd_lim), .wr_lim(wr_lim)
);

// File: tb/lbp_mem_model_test.sv
`timescale 1ns/1ps
module lbp_mem_model_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        awvalid, awready, wvalid, wready, wlast, bvalid, bready;
  logic [3:0]  awid, bid, arid, rid;
  logic [15:0] awaddr, araddr;
  logic [7:0]  awlen, arlen;
  logic [31:0] wdata, rdata;
  logic [3:0]  wstrb;
  logic [1:0]  bresp, rresp;
  logic        arvalid, arready, rvalid, rready, rlast;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [31:0] shadow [64];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lbp_mem_model uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr), .awlen(awlen),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr), .arlen(arlen),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one write burst; returns cycles from WLAST edge to bvalid
  task automatic do_write(input logic [3:0] id, input logic [15:0] addr, input logic [7:0] len,
                          input logic [31:0] base, input logic [3:0] strb, output int lat);
    int c0;
    @(negedge clk);
    awvalid = 1'b1; awid = id; awaddr = addr; awlen = len;
    @(negedge clk);
    awvalid = 1'b0;
    for (int b = 0; b <= int'(len); b++) begin
      int idx = (int'(addr >> 2) + b) % 64;
      wvalid = 1'b1; wdata = base + 32'(b); wstrb = strb; wlast = (b == int'(len));
      for (int l = 0; l < 4; l++)
        if (strb[l]) shadow[idx][8*l +: 8] = wdata[8*l +: 8];
      @(negedge clk);
    end
    wvalid = 1'b0; wlast = 1'b0;
    c0 = cyc;
    while (!bvalid && cyc - c0 < 300) @(negedge clk);
    lat = cyc - c0;
    chk(bid == id, "R6 bid echo", bid, id);
    @(negedge clk);
  endtask

  // one read burst; data and last flag checked per beat; returns first-beat latency
  task automatic do_read(input logic [3:0] id, input logic [15:0] addr, input logic [7:0] len,
                         output int lat);
    int c0;
    @(negedge clk);
    arvalid = 1'b1; arid = id; araddr = addr; arlen = len;
    @(negedge clk);
    arvalid = 1'b0;
    c0 = cyc;
    lat = -1;
    for (int b = 0; b <= int'(len); b++) begin
      int idx = (int'(addr >> 2) + b) % 64;
      while (!rvalid && cyc - c0 < 300) @(negedge clk);
      if (b == 0) lat = cyc - c0;
      chk(rdata == shadow[idx], "R8 read data", rdata, shadow[idx]);
      chk(rlast == (b == int'(len)), "R8 rlast position", rlast, (b == int'(len)));
      chk(rid == id, "R6 rid echo", rid, id);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int lat, acc, cnt;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    awvalid = 1'b0; awid = '0; awaddr = '0; awlen = '0;
    wvalid = 1'b0; wdata = '0; wstrb = '0; wlast = 1'b0;
    arvalid = 1'b0; arid = '0; araddr = '0; arlen = '0;
    rready = 1'b1; bready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(arready == 1'b1, "R10 arready", arready, 1);
    chk(awready == 1'b1, "R10 awready", awready, 1);
    chk(rvalid == 1'b0 && bvalid == 1'b0, "R10 valids low", {rvalid, bvalid}, 0);
    chk(wready == 1'b0, "R10 wready", wready, 0);

    // R8 data path with default latencies (R10 reset latency values)
    do_write(4'd1, 16'h0040, 8'd3, 32'h0000_00A0, 4'hF, lat);
    chk(lat == 2, "R10 reset write latency", lat, 2);
    do_write(4'd2, 16'h0044, 8'd0, 32'hFFFF_FFFF, 4'b0101, lat);
    do_write(4'd3, 16'h00FC, 8'd1, 32'h1234_5670, 4'hF, lat); // wraps word 63 -> 0
    do_read(4'd4, 16'h0040, 8'd3, lat);
    chk(lat == 4, "R10 reset read latency", lat, 4);
    do_read(4'd5, 16'h00FC, 8'd1, lat);

    // R1 read latency sweep
    for (int l = 0; l <= 7; l++) begin
      cfg_write(2'd0, 8'(l));
      do_read(4'(l), 16'h0040, 8'd0, lat);
      chk(lat == l, "R1 read latency", lat, l);
    end

    // R2 write latency sweep
    for (int l = 0; l <= 7; l++) begin
      cfg_write(2'd1, 8'(l));
      do_write(4'(l + 8), 16'(16'h0080 + 4 * l), 8'd0, 32'(32'h5500 + l), 4'hF, lat);
      chk(lat == l, "R2 write latency", lat, l);
    end

    // R7 in-flight read keeps its latency; R6 order kept
    cfg_write(2'd0, 8'd8);
    @(negedge clk); arvalid = 1'b1; arid = 4'd5; araddr = 16'h0040; arlen = 8'd0;
    @(negedge clk); arvalid = 1'b0;
    acc = cyc;
    cfg_write(2'd0, 8'd1);
    @(negedge clk); arvalid = 1'b1; arid = 4'd6;
    @(negedge clk); arvalid = 1'b0;
    while (!rvalid && cyc - acc < 300) @(negedge clk);
    chk(cyc - acc == 8, "R7 old latency kept", cyc - acc, 8);
    chk(rid == 4'd5, "R6 first read first", rid, 5);
    @(negedge clk);
    chk(rvalid == 1'b1 && rid == 4'd6, "R6 second read next", rid, 6);
    @(negedge clk);

    // R3 read cap of 2, R9 hold under back-pressure
    cfg_write(2'd0, 8'd30);
    cfg_write(2'd2, 8'd2);
    rready = 1'b0; acc = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      arvalid = 1'b1; arid = 4'(acc); araddr = 16'h0040; arlen = 8'd0;
      if (arready) acc++;
    end
    @(negedge clk); arvalid = 1'b0;
    chk(acc == 2, "R3 cap of two", acc, 2);
    chk(arready == 1'b0, "R3 arready low at cap", arready, 0);
    repeat (40) @(negedge clk);
    chk(rvalid == 1'b1 && rid == 4'd0, "R9 rvalid held", rid, 0);
    @(negedge clk);
    chk(rvalid == 1'b1 && rid == 4'd0, "R9 rid stable", rid, 0);
    rready = 1'b1;
    @(negedge clk);
    chk(rvalid == 1'b1 && rid == 4'd1, "R6 read order", rid, 1);
    repeat (3) @(negedge clk);

    // R3 cap of zero blocks, cap above MAX_OUT clamps to 4
    cfg_write(2'd2, 8'd0);
    @(negedge clk);
    chk(arready == 1'b0, "R3 cap zero", arready, 0);
    cfg_write(2'd2, 8'd9);
    rready = 1'b0; acc = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      arvalid = 1'b1; arid = 4'(acc);
      if (arready) acc++;
    end
    @(negedge clk); arvalid = 1'b0;
    chk(acc == 4, "R3 cap clamps to depth", acc, 4);
    rready = 1'b1;
    repeat (50) @(negedge clk);

    // R4 write cap of 1 and the open-burst block
    cfg_write(2'd3, 8'd1);
    cfg_write(2'd1, 8'd3);
    bready = 1'b0;
    @(negedge clk); awvalid = 1'b1; awid = 4'd7; awaddr = 16'h0010; awlen = 8'd0;
    @(negedge clk); awvalid = 1'b0;
    chk(awready == 1'b0, "R4 awready low while burst open", awready, 0);
    chk(wready == 1'b1, "R4 wready in burst", wready, 1);
    wvalid = 1'b1; wdata = 32'hCAFE_0001; wstrb = 4'hF; wlast = 1'b1;
    @(negedge clk); wvalid = 1'b0; wlast = 1'b0;
    shadow[4] = 32'hCAFE_0001;
    chk(wready == 1'b0, "R4 wready low after burst", wready, 0);
    repeat (10) @(negedge clk);
    chk(bvalid == 1'b1 && bid == 4'd7, "R9 bvalid held", bid, 7);
    chk(awready == 1'b0, "R4 awready low at cap", awready, 0);
    bready = 1'b1;
    @(negedge clk);
    chk(awready == 1'b1, "R4 awready back after response", awready, 1);
    cfg_write(2'd3, 8'd4);

    // R5 throughput sweep over latency and cap pairs
    for (int p = 0; p < 5; p++) begin
      int l, n, k, exp_n;
      case (p)
        0: begin l = 3; n = 2; end
        1: begin l = 2; n = 3; end
        2: begin l = 6; n = 4; end
        3: begin l = 0; n = 1; end
        default: begin l = 2; n = 4; end
      endcase
      k = 5;
      exp_n = k * ((n < l + 2) ? n : l + 2);
      cfg_write(2'd0, 8'(l));
      cfg_write(2'd2, 8'(n));
      @(negedge clk);
      arvalid = 1'b1; arid = 4'd9; araddr = 16'h0040; arlen = 8'd0; rready = 1'b1;
      repeat (60) @(negedge clk);
      cnt = 0;
      for (int c = 0; c < k * (l + 2); c++) begin
        if (rvalid && rready) cnt++;
        @(negedge clk);
      end
      chk(cnt == exp_n, "R5 steady-state beats", cnt, exp_n);
      arvalid = 1'b0;
      repeat (40) @(negedge clk);
    end

    finish_run();
  end
endmodule